// File: doc/BRIEF.md
# Serial Code Sequence Checker

The checker watches a serial line that delivers one bit per clock cycle whenever a sample-valid strobe is high. It compares the incoming bits, most significant code bit first, against a fixed 8-bit code (by default `11001000`, set through a parameter at build time). When the eighth bit of an unbroken correct run arrives, the block lights the digit "1" on a single seven-segment display and raises a debug match flag. In every other case the display shows "0".

The design is a Moore machine with nine named states: `S_IDLE` (nothing matched), `S_B1` to `S_B7` (that many leading code bits matched) and `S_HIT` (full code seen). On each valid bit, state `S_IDLE` or `S_Bk` moves to the next state when the bit equals the next code bit. Otherwise it returns to `S_IDLE`. The wrong bit is discarded and is not taken as a new first bit. `S_HIT` holds until the next valid bit, which is judged as the first bit of a fresh attempt: it goes to `S_B1` on a match and to `S_IDLE` otherwise. Cycles without valid leave the state unchanged. Any encoding outside the nine states returns to `S_IDLE` on the next clock.

Top module: `seqchk_top`

## Requirements
- R1: An active-low asynchronous reset puts the machine in its start state at once. The display then shows "0" and the match flag is low.
- R2: After eight consecutive valid bits equal to the code, taken most significant bit first, the match flag is high from the clock edge that takes the eighth bit. The segment output is then `0000110`, active-high, in bit order g f e d c b a (bit 6 = g, bit 0 = a).
- R3: Whenever the full code has not just been matched, the match flag is low and the segment output is `0111111` (the digit 0).
- R4: A valid bit that differs from the expected code bit returns the machine to its start state. That bit is not reused as a first bit, so a later match needs eight more correct bits.
- R5: In cycles where the valid strobe is low, the state, the segment output and the match flag do not change, whatever the data input does.
- R6: After a full match, the "1" stays on until the next valid bit. That bit counts as the first bit of a new attempt, so two codes sent back to back both give a match.
- R7: The code is a build parameter. An instance built with another 8-bit code matches that code and not the default one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Serial data bit |
| valid_i | input | 1 | High when bit_i carries a sample this cycle |
| seg_o | output | 7 | Seven-segment drive, active-high, bit 6 = g down to bit 0 = a |
| match_o | output | 1 | Debug flag, high while the full code is matched |

## Verification
The bench flips each of the eight code positions in turn. A checker whose transition is wrong at any single position would either miss the error or block a clean match. A run of three ones followed by the code's tail catches a design that reuses overlapping bits, because such a design would report a false match. Gaps with toggling data inside a code expose a design that samples without valid. Back-to-back codes, and a wrong bit right after a match, show whether the "1" is cleared at the right edge and whether the next attempt starts at the right place. A second instance with another code proves that the parameter, and not a hard-wired pattern, drives the comparison.

// File: rtl/seqchk_pkg.sv
package seqchk_pkg;

    localparam int CODE_LEN = 8;
    localparam int SEG_W    = 7;

    typedef enum logic [3:0] {
        S_IDLE = 4'd0,
        S_B1   = 4'd1,
        S_B2   = 4'd2,
        S_B3   = 4'd3,
        S_B4   = 4'd4,
        S_B5   = 4'd5,
        S_B6   = 4'd6,
        S_B7   = 4'd7,
        S_HIT  = 4'd8
    } seq_state_e;

    // active-high glyphs, bit order g f e d c b a
    localparam logic [SEG_W-1:0] GLYPH_ZERO = 7'b0111111;
    localparam logic [SEG_W-1:0] GLYPH_ONE  = 7'b0000110;

endpackage

// File: rtl/seqchk_next.sv
module seqchk_next
    import seqchk_pkg::*;
#(
    parameter logic [CODE_LEN-1:0] CODE = 8'b11001000
) (
    input  seq_state_e cur_i,
    input  logic       valid_i,
    input  logic       bit_i,
    output seq_state_e nxt_o
);

    // expected bit for each prefix length, first code bit is the MSB
    logic [CODE_LEN-1:0] want;

    genvar gi;
    generate
        for (gi = 0; gi < CODE_LEN; gi++) begin : g_want
            assign want[gi] = CODE[CODE_LEN-1-gi];
        end
    endgenerate

    always_comb begin
        nxt_o = cur_i;
        unique case (cur_i)
            S_IDLE: if (valid_i) nxt_o = (bit_i == want[0]) ? S_B1  : S_IDLE;
            S_B1:   if (valid_i) nxt_o = (bit_i == want[1]) ? S_B2  : S_IDLE;
            S_B2:   if (valid_i) nxt_o = (bit_i == want[2]) ? S_B3  : S_IDLE;
            S_B3:   if (valid_i) nxt_o = (bit_i == want[3]) ? S_B4  : S_IDLE;
            S_B4:   if (valid_i) nxt_o = (bit_i == want[4]) ? S_B5  : S_IDLE;
            S_B5:   if (valid_i) nxt_o = (bit_i == want[5]) ? S_B6  : S_IDLE;
            S_B6:   if (valid_i) nxt_o = (bit_i == want[6]) ? S_B7  : S_IDLE;
            S_B7:   if (valid_i) nxt_o = (bit_i == want[7]) ? S_HIT : S_IDLE;
            // a fresh attempt starts with the bit after a full match
            S_HIT:  if (valid_i) nxt_o = (bit_i == want[0]) ? S_B1  : S_IDLE;
            default: nxt_o = S_IDLE;
        endcase
    end

endmodule

// File: rtl/seqchk_seg7.sv
module seqchk_seg7
    import seqchk_pkg::*;
(
    input  logic [3:0]       digit_i,
    output logic [SEG_W-1:0] seg_o
);

    always_comb begin
        unique case (digit_i)
            4'd0:    seg_o = GLYPH_ZERO;
            4'd1:    seg_o = GLYPH_ONE;
            4'd2:    seg_o = 7'b1011011;
            4'd3:    seg_o = 7'b1001111;
            4'd4:    seg_o = 7'b1100110;
            4'd5:    seg_o = 7'b1101101;
            4'd6:    seg_o = 7'b1111101;
            4'd7:    seg_o = 7'b0000111;
            4'd8:    seg_o = 7'b1111111;
            4'd9:    seg_o = 7'b1101111;
            default: seg_o = 7'b1000000;
        endcase
    end

endmodule

// File: rtl/seqchk_top.sv
module seqchk_top
    import seqchk_pkg::*;
#(
    parameter logic [CODE_LEN-1:0] CODE = 8'b11001000
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             bit_i,
    input  logic             valid_i,
    output logic [SEG_W-1:0] seg_o,
    output logic             match_o
);

    seq_state_e state_q;
    seq_state_e state_d;
    logic [3:0] digit;

    seqchk_next #(
        .CODE (CODE)
    ) u_next (
        .cur_i   (state_q),
        .valid_i (valid_i),
        .bit_i   (bit_i),
        .nxt_o   (state_d)
    );

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Moore outputs
    always_comb begin
        unique case (state_q)
            S_HIT: begin
                match_o = 1'b1;
                digit   = 4'd1;
            end
            default: begin
                match_o = 1'b0;
                digit   = 4'd0;
            end
        endcase
    end

    seqchk_seg7 u_seg (
        .digit_i (digit),
        .seg_o   (seg_o)
    );

endmodule

// File: rtl/seqchk_chk.sv
module seqchk_chk
    import seqchk_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic             valid_i,
    input logic [SEG_W-1:0] seg_o,
    input logic             match_o
);

    // R2
    glyph_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_o |-> seg_o == GLYPH_ONE);

    // R3
    glyph_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !match_o |-> seg_o == GLYPH_ZERO);

    // R5
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> $stable(match_o) && $stable(seg_o));

    // R2
    rise_on_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(match_o) |-> $past(valid_i));

    // R6
    hit_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_o && valid_i |=> !match_o);

endmodule

bind seqchk_top seqchk_chk u_seqchk_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .seg_o   (seg_o),
    .match_o (match_o)
);

// File: tb/test_seqchk_top.sv
module test_seqchk_top;

    localparam logic [7:0] CODE_A = 8'b11001000;
    localparam logic [7:0] CODE_B = 8'b10110101;
    localparam logic [6:0] G0 = 7'b0111111;
    localparam logic [6:0] G1 = 7'b0000110;
    localparam int NVEC = 10;

    // {word sent MSB first, expected final match on the default code}
    localparam logic [8:0] VEC [NVEC] = '{
        {8'hC8, 1'b1},
        {8'h48, 1'b0}, {8'h88, 1'b0}, {8'hE8, 1'b0}, {8'hD8, 1'b0},
        {8'hC0, 1'b0}, {8'hCC, 1'b0}, {8'hCA, 1'b0}, {8'hC9, 1'b0},
        {8'hC8, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       din = 1'b0;
    logic       vld = 1'b0;
    logic [6:0] seg_a, seg_b;
    logic       hit_a, hit_b;

    int n_checks = 0;
    int n_errors = 0;
    int k_a = 0;
    int k_b = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    seqchk_top i_seqchk_top (
        .clk_i (clk), .rst_ni (rst_n), .bit_i (din), .valid_i (vld),
        .seg_o (seg_a), .match_o (hit_a)
    );

    seqchk_top #(.CODE (CODE_B)) i_seqchk_top_alt (
        .clk_i (clk), .rst_ni (rst_n), .bit_i (din), .valid_i (vld),
        .seg_o (seg_b), .match_o (hit_b)
    );

    function automatic int step(int k, logic [7:0] code, logic b);
        int kk;
        kk = (k == 8) ? 0 : k;
        if (b == code[7-kk]) return kk + 1;
        return 0;
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic chk_outputs(string tag);
        chk({tag, " match A"}, {7'd0, hit_a}, {7'd0, k_a == 8});
        chk({tag, " seg A"}, {1'b0, seg_a}, {1'b0, (k_a == 8) ? G1 : G0});
        chk({tag, " match B"}, {7'd0, hit_b}, {7'd0, k_b == 8});
    endtask

    // call at a falling edge; returns at the next falling edge
    task automatic send_bit(logic b, string tag);
        din = b;
        vld = 1'b1;
        @(negedge clk);
        vld = 1'b0;
        k_a = step(k_a, CODE_A, b);
        k_b = step(k_b, CODE_B, b);
        chk_outputs(tag);
    endtask

    task automatic send_word(logic [7:0] w, string tag);
        for (int i = 7; i >= 0; i--) send_bit(w[i], tag);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) begin
            din = ~din;
            @(negedge clk);
            chk_outputs(tag);
        end
    endtask

    task automatic do_reset();
        #1 rst_n = 1'b0;
        k_a = 0;
        k_b = 0;
        #1 chk_outputs("R1 async reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (2) @(negedge clk);
        chk_outputs("R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R2 full code, R4 error at each of the 8 positions
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            send_word(VEC[v][8:1], "R2/R4 table bit");
            chk("R2/R4 table final", {7'd0, hit_a}, {7'd0, VEC[v][0]});
        end

        // R3: a partial prefix leaves the digit 0
        do_reset();
        send_word(8'hC8 >> 1, "R3 partial");
        chk("R3 partial glyph", {1'b0, seg_a}, {1'b0, G0});

        // R4: no overlap reuse, 1 1 1 then the code tail
        do_reset();
        send_bit(1'b1, "R4 no reuse");
        send_bit(1'b1, "R4 no reuse");
        send_bit(1'b1, "R4 no reuse");
        for (int i = 5; i >= 0; i--) send_bit(CODE_A[i], "R4 no reuse");
        chk("R4 no overlap match", {7'd0, hit_a}, 8'd0);

        // R5: gaps with toggling data inside a code
        do_reset();
        for (int i = 7; i >= 0; i--) begin
            send_bit(CODE_A[i], "R5 gapped");
            idle(3, "R5 gap hold");
        end
        chk("R5 gapped code matches", {7'd0, hit_a}, 8'd1);

        // R6: display held, then back-to-back codes
        idle(5, "R6 hold after match");
        chk("R6 one still shown", {1'b0, seg_a}, {1'b0, G1});
        send_word(CODE_A, "R6 back to back");
        chk("R6 second match", {7'd0, hit_a}, 8'd1);
        send_word(CODE_A, "R6 back to back");
        chk("R6 third match", {7'd0, hit_a}, 8'd1);
        send_bit(1'b0, "R6 wrong first bit");
        chk("R6 cleared after match", {1'b0, seg_a}, {1'b0, G0});

        // R7: alternate code on the second instance
        do_reset();
        send_word(CODE_B, "R7 alt code");
        chk("R7 alt instance matches", {7'd0, hit_b}, 8'd1);
        chk("R7 default instance idle", {7'd0, hit_a}, 8'd0);

        // R1: reset in the middle of a code
        send_word(8'hC8 >> 4, "R1 prefix");
        do_reset();
        send_word(CODE_A, "R1 after reset");
        chk("R1 match after mid reset", {7'd0, hit_a}, 8'd1);

        finish_run();
    end

endmodule